// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Logic

This block keeps the eight-bit status byte of an I2C controller and decides, cycle by cycle, when each flag rises and falls. It samples the bus lines SCL and SDA through a synchronizer and finds START and STOP conditions. It counts the nine clocks of every byte and records the acknowledge level. It shifts in the first byte after each START and compares its upper seven bits with a programmable own address.

The controller core supplies an arbitration-lost strobe and a transmit/receive mode level. A register port supplies one-cycle strobes for data-register reads and writes, control-register writes and status-register writes with write data. The status byte is presented continuously. A registered interrupt request combines the pending flag with an enable input. This block does not drive the bus lines or generate clocks.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset `status_o` reads 0x81: transfer-complete (bit 7) and received-acknowledge (bit 0) are 1, every other bit is 0. `irq_o` is 0. Bit 3 always reads 0.
- R2: Bus-busy (bit 5) sets when SDA falls while SCL is high (START) and clears when SDA rises while SCL is high (STOP). Both are judged on the synchronized lines.
- R3: Transfer-complete (bit 7) sets on the falling SCL edge that ends the 9th clock of a byte. With `tx_mode_i`=0 a `dr_rd_i` strobe clears it. With `tx_mode_i`=1 a `dr_wr_i` strobe clears it. The other strobe has no effect. If a byte ends in the same cycle as a clearing strobe, the flag ends up set.
- R4: Received-acknowledge (bit 0) takes the SDA level sampled at the rising edge of the 9th clock. It is updated when that byte ends: 0 means acknowledged, 1 means not acknowledged.
- R5: Addressed-as-slave (bit 6) sets when the first byte after a START ends and its bits 7:1 (sent MSB first) equal `own_addr_i`. A non-matching byte, or any later byte, does not set it. Any `cr_wr_i` strobe clears it.
- R6: Slave read/write (bit 2) loads bit 0 of a matching address byte (1 = master reads, 0 = master writes). It is otherwise held.
- R7: Arbitration-lost (bit 4) sets on `arb_lost_i`. It clears only on a `sr_wr_i` strobe with write-data bit 4 equal to 0; writing 1 there keeps it. A set and a clear in the same cycle leave it set.
- R8: Interrupt-pending (bit 1) sets at the end of every byte, on an own-address match with R/W bit 0, and on `arb_lost_i`. It clears only on a `sr_wr_i` strobe with write-data bit 1 equal to 0, and a simultaneous set wins.
- R9: Status writes have no effect on bits 7, 6, 5, 3, 2 and 0.
- R10: `irq_o` equals interrupt-pending AND `int_en_i` as seen one clock earlier.
- R11: A START or STOP resets the bit count, so a repeated START in the middle of a byte starts a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| own_addr_i | input | 7 | Own slave address |
| int_en_i | input | 1 | Interrupt enable from control register |
| tx_mode_i | input | 1 | 1 = transmit mode, 0 = receive mode |
| arb_lost_i | input | 1 | Arbitration-lost strobe from core |
| dr_rd_i | input | 1 | Data-register read strobe |
| dr_wr_i | input | 1 | Data-register write strobe |
| cr_wr_i | input | 1 | Control-register write strobe |
| sr_wr_i | input | 1 | Status-register write strobe |
| sr_wdata_i | input | 8 | Status-register write data |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two collisions matter most. The first is a byte ending in the same cycle as the data-register access that clears transfer-complete. The bench times the `dr_rd_i` strobe to the third clock edge after it drives the final SCL fall, which counts the two synchronizer stages. The second is `arb_lost_i` arriving in the same cycle as a status write that zeroes bits 4 and 1. In both cases the set must win, and the bench reads the status byte afterwards to confirm the flag stayed at 1.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned SYNC_LEN  = 2;

  // bit positions decoded by software
  localparam int unsigned B_XFER = 7;
  localparam int unsigned B_AAS  = 6;
  localparam int unsigned B_BUSY = 5;
  localparam int unsigned B_ARB  = 4;
  localparam int unsigned B_RSV  = 3;
  localparam int unsigned B_SRW  = 2;
  localparam int unsigned B_PEND = 1;
  localparam int unsigned B_NACK = 0;

  localparam logic [STAT_W-1:0] STAT_RST = 8'h81;

  typedef struct packed {
    logic xfer;
    logic aas;
    logic busy;
    logic arb;
    logic rsv;
    logic srw;
    logic pend;
    logic nack;
  } stat_t;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_LEN-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;

  generate
    for (genvar g = 0; g < SYNC_LEN; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync[g] <= 1'b1;
          sda_sync[g] <= 1'b1;
        end else if (g == 0) begin
          scl_sync[g] <= scl_i;
          sda_sync[g] <= sda_i;
        end else begin
          scl_sync[g] <= scl_sync[(g == 0) ? 0 : g-1];
          sda_sync[g] <= sda_sync[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_sync[SYNC_LEN-1];
  assign sda_s = sda_sync[SYNC_LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_track.sv
module i2c_byte_track #(
  parameter int unsigned BYTE_BITS = 8,
  parameter int unsigned ADDR_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              byte_done_o,
  output logic              ack_o,
  output logic              addr_hit_o,
  output logic              rw_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_BITS + 1);

  logic [CNT_W-1:0]     cnt_q;
  logic [BYTE_BITS-1:0] shreg_q;
  logic                 ack_q;
  logic                 first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      ack_q   <= 1'b1;
      first_q <= 1'b0;
    end else if (start_i || stop_i) begin
      cnt_q   <= '0;
      first_q <= start_i;
    end else if (scl_rise_i) begin
      if (cnt_q < ACK_SLOT) shreg_q <= {shreg_q[BYTE_BITS-2:0], sda_i};
      if (cnt_q == ACK_SLOT) ack_q <= sda_i;
      if (cnt_q <= ACK_SLOT) cnt_q <= cnt_q + 1'b1;
    end else if (scl_fall_i && cnt_q == LAST_CNT) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end
  end

  assign byte_done_o = scl_fall_i && (cnt_q == LAST_CNT) && !start_i && !stop_i;
  assign ack_o       = ack_q;
  assign rw_o        = shreg_q[0];
  assign addr_hit_o  = byte_done_o && first_q && (shreg_q[BYTE_BITS-1 -: ADDR_W] == own_addr_i);
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_done_i,
  input  logic              ack_i,
  input  logic              addr_hit_i,
  input  logic              rw_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              arb_lost_i,
  input  logic              tx_mode_i,
  input  logic              dr_rd_i,
  input  logic              dr_wr_i,
  input  logic              cr_wr_i,
  input  logic              sr_wr_i,
  input  logic [STAT_W-1:0] sr_wdata_i,
  input  logic              int_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  stat_t st_q;
  logic  irq_q;
  logic  dr_touch, arb_clr, pend_clr, pend_set;

  assign dr_touch = tx_mode_i ? dr_wr_i : dr_rd_i;
  assign arb_clr  = sr_wr_i & ~sr_wdata_i[B_ARB];
  assign pend_clr = sr_wr_i & ~sr_wdata_i[B_PEND];
  assign pend_set = byte_done_i | arb_lost_i | (addr_hit_i & ~rw_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= stat_t'(STAT_RST);
      irq_q <= 1'b0;
    end else begin
      if (byte_done_i)   st_q.xfer <= 1'b1;
      else if (dr_touch) st_q.xfer <= 1'b0;

      if (addr_hit_i)   st_q.aas <= 1'b1;
      else if (cr_wr_i) st_q.aas <= 1'b0;

      if (start_i)     st_q.busy <= 1'b1;
      else if (stop_i) st_q.busy <= 1'b0;

      if (arb_lost_i)   st_q.arb <= 1'b1;
      else if (arb_clr) st_q.arb <= 1'b0;

      st_q.rsv <= 1'b0;

      if (addr_hit_i) st_q.srw <= rw_i;

      if (pend_set)      st_q.pend <= 1'b1;
      else if (pend_clr) st_q.pend <= 1'b0;

      if (byte_done_i) st_q.nack <= ack_i;

      irq_q <= st_q.pend & int_en_i;
    end
  end

  assign status_o = st_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              int_en_i,
  input  logic              tx_mode_i,
  input  logic              arb_lost_i,
  input  logic              dr_rd_i,
  input  logic              dr_wr_i,
  input  logic              cr_wr_i,
  input  logic              sr_wr_i,
  input  logic [STAT_W-1:0] sr_wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic byte_done, ack, addr_hit, rw;

  i2c_line_mon #(.SYNC_LEN(SYNC_LEN)) u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  i2c_byte_track #(.BYTE_BITS(BYTE_BITS), .ADDR_W(ADDR_W)) u_track (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop), .own_addr_i,
    .byte_done_o(byte_done), .ack_o(ack), .addr_hit_o(addr_hit), .rw_o(rw)
  );

  i2c_stat_reg u_reg (
    .clk_i, .rst_ni,
    .byte_done_i(byte_done), .ack_i(ack), .addr_hit_i(addr_hit), .rw_i(rw),
    .start_i(bus_start), .stop_i(bus_stop),
    .arb_lost_i, .tx_mode_i, .dr_rd_i, .dr_wr_i, .cr_wr_i, .sr_wr_i, .sr_wdata_i,
    .int_en_i, .status_o, .irq_o
  );
endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk
  import i2c_stat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] status_o,
  input logic              irq_o,
  input logic              int_en_i,
  input logic              tx_mode_i,
  input logic              arb_lost_i,
  input logic              dr_wr_i,
  input logic              cr_wr_i,
  input logic              sr_wr_i,
  input logic [STAT_W-1:0] sr_wdata_i,
  input logic              addr_hit,
  input logic              byte_done,
  input logic              bus_start
);
  always_comb begin
    if (rst_ni) assert_rsv_zero_R1: assert (status_o[B_RSV] == 1'b0);
  end

  assert_busy_on_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start |=> status_o[B_BUSY]);

  assert_xfer_clear_tx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_mode_i && dr_wr_i && !byte_done) |=> !status_o[B_XFER]);

  assert_aas_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_wr_i && !addr_hit) |=> !status_o[B_AAS]);

  assert_arb_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[B_ARB] && !(sr_wr_i && !sr_wdata_i[B_ARB])) |=> status_o[B_ARB]);

  assert_arb_sets_pend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i |=> (status_o[B_ARB] && status_o[B_PEND]));

  assert_irq_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(status_o[B_PEND] & int_en_i)));
endmodule

bind i2c_stat_flags i2c_stat_flags_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .status_o(status_o), .irq_o(irq_o),
  .int_en_i(int_en_i), .tx_mode_i(tx_mode_i), .arb_lost_i(arb_lost_i),
  .dr_wr_i(dr_wr_i), .cr_wr_i(cr_wr_i), .sr_wr_i(sr_wr_i),
  .sr_wdata_i(sr_wdata_i), .addr_hit(addr_hit), .byte_done(byte_done),
  .bus_start(bus_start)
);

// File: tb/i2c_stat_flags_test.sv
`timescale 1ns/1ps
module i2c_stat_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic [6:0] own = 7'h5A;
  logic       int_en = 1'b0, tx_mode = 1'b0, arb = 1'b0;
  logic       dr_rd = 1'b0, dr_wr = 1'b0, cr_wr = 1'b0, sr_wr = 1'b0;
  logic [7:0] sr_wdata = 8'h00;
  logic [7:0] status;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic e_xfer = 1, e_aas = 0, e_busy = 0, e_arb = 0, e_srw = 0, e_pend = 0, e_nack = 1;

  always #10 clk = ~clk;

  i2c_stat_flags uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .own_addr_i(own),
    .int_en_i(int_en), .tx_mode_i(tx_mode), .arb_lost_i(arb),
    .dr_rd_i(dr_rd), .dr_wr_i(dr_wr), .cr_wr_i(cr_wr), .sr_wr_i(sr_wr),
    .sr_wdata_i(sr_wdata), .status_o(status), .irq_o(irq)
  );

  function automatic logic [7:0] exp_stat();
    return {e_xfer, e_aas, e_busy, e_arb, 1'b0, e_srw, e_pend, e_nack};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, status, exp_stat());
    chk({req, " R10 irq"}, {7'd0, irq}, {7'd0, e_pend & int_en});
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin sda = 1'b1; half(); end
    scl = 1'b1; half();
    sda = 1'b0; half();
    scl = 1'b0; half();
    e_busy = 1'b1;
  endtask

  task automatic bus_stop();
    sda = 1'b0; half();
    scl = 1'b1; half();
    sda = 1'b1; half();
    e_busy = 1'b0;
  endtask

  task automatic clk_bit(input logic b);
    sda = b; half();
    scl = 1'b1; half();
    scl = 1'b0; half();
  endtask

  task automatic send_byte(input logic [7:0] v, input logic nack, input bit first);
    for (int i = 7; i >= 0; i--) clk_bit(v[i]);
    clk_bit(nack);
    e_xfer = 1'b1; e_nack = nack; e_pend = 1'b1;
    if (first && v[7:1] == own) begin
      e_aas = 1'b1; e_srw = v[0];
    end
  endtask

  task automatic pulse_dr(input bit wr);
    @(negedge clk);
    if (wr) dr_wr = 1'b1; else dr_rd = 1'b1;
    @(negedge clk);
    dr_wr = 1'b0; dr_rd = 1'b0;
    if (wr == tx_mode) e_xfer = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_cr();
    @(negedge clk); cr_wr = 1'b1;
    @(negedge clk); cr_wr = 1'b0;
    e_aas = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_sr(input logic [7:0] v, input bit with_arb);
    @(negedge clk); sr_wr = 1'b1; sr_wdata = v; arb = with_arb;
    @(negedge clk); sr_wr = 1'b0; arb = 1'b0;
    if (with_arb) begin
      e_arb = 1'b1; e_pend = 1'b1;
    end else begin
      e_arb &= v[4]; e_pend &= v[1];
    end
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C5EED));
    repeat (3) @(negedge clk);
    chk("R1 reset", status, 8'h81);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R1 after release");

    // directed: matched address, master writes
    int_en = 1'b1;
    bus_start();
    chk_all("R2 start sets busy");
    send_byte({own, 1'b0}, 1'b0, 1);
    chk_all("R5 R6 R8 R4 match write");
    pulse_cr();
    chk_all("R5 control write clears");
    pulse_dr(1'b1);
    chk_all("R3 dr write in rx no effect");
    pulse_dr(1'b0);
    chk_all("R3 dr read in rx clears");
    write_sr(8'hFF, 0);
    chk_all("R9 write ones ignored");
    write_sr(8'h00, 0);
    chk_all("R8 R9 write zeros");
    send_byte(8'h3C, 1'b1, 0);
    chk_all("R4 nack, R5 later byte no match");
    bus_stop();
    chk_all("R2 stop clears busy");

    // R11: repeated start mid-byte restarts address
    write_sr(8'h00, 0); pulse_cr();
    bus_start();
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
    bus_start();
    send_byte({own, 1'b1}, 1'b0, 1);
    chk_all("R11 R6 repeated start address");
    bus_stop();

    // R3 collision: byte end with dr_rd in same cycle
    tx_mode = 1'b0;
    bus_start();
    for (int i = 7; i >= 0; i--) clk_bit(i[0]);
    sda = 1'b0; half(); scl = 1'b1; half();
    scl = 1'b0;
    @(negedge clk); @(negedge clk);
    dr_rd = 1'b1;
    @(negedge clk); dr_rd = 1'b0;
    e_xfer = 1'b1; e_nack = 1'b0; e_pend = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R3 set wins over dr read");
    tx_mode = 1'b1;
    pulse_dr(1'b0);
    chk_all("R3 dr read in tx no effect");
    pulse_dr(1'b1);
    chk_all("R3 dr write in tx clears");
    bus_stop();

    // R7/R8 collision
    write_sr(8'h00, 1);
    chk_all("R7 R8 arb set wins over clear");
    write_sr(8'h10, 0);
    chk_all("R7 write one keeps arb");
    int_en = 1'b0; repeat (3) @(negedge clk);
    chk_all("R10 irq masked");
    write_sr(8'h00, 0);
    chk_all("R7 cleared");
    int_en = 1'b1;

    // random traffic
    for (int it = 0; it < 40; it++) begin
      logic [7:0] a;
      int nb;
      tx_mode = $urandom_range(0, 1);
      int_en  = $urandom_range(0, 3) != 0;
      a = ($urandom_range(0, 1) != 0) ? {own, 1'($urandom_range(0, 1))} : 8'($urandom);
      bus_start();
      send_byte(a, 1'($urandom_range(0, 1)), 1);
      chk_all("R5 R6 R4 random address");
      nb = $urandom_range(0, 2);
      for (int b = 0; b < nb; b++) begin
        send_byte(8'($urandom), 1'($urandom_range(0, 1)), 0);
        chk_all("R3 R4 R8 random data");
      end
      case ($urandom_range(0, 4))
        0: pulse_dr(1'($urandom_range(0, 1)));
        1: pulse_cr();
        2: write_sr(8'($urandom), 0);
        3: write_sr(8'($urandom), 1);
        default: ;
      endcase
      repeat (2) @(negedge clk);
      chk_all("R3 R5 R7 R8 R9 random software");
      if ($urandom_range(0, 1) != 0) begin
        bus_stop();
        chk_all("R2 random stop");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule